// File: doc/BRIEF.md
# Chained Strip-Plane Event and Monitor Node

This block sits on one detector plane and serves two serial chains that a back-end controller drives in common. On a final trigger it freezes a 48-bit event record made of the plane's board identity, four group (fold) flags, the number of the channel currently under monitoring and the 32 strip-hit states. In event mode every node on a chain shifts its record towards the controller one bit per event-clock strobe. The bit arriving on scan-in enters at the bottom, so after 48 strobes a node holds its upstream neighbour's record and the whole chain of up to 16 nodes drains through the last scan-out.

In monitor mode the same 4-bit address bus picks one node. The first monitor-clock pulse that finds the address matching arms that node. Each later matching pulse steps a channel counter over 40 sources: the 32 strips, four calibration frequencies and four group signals. The chosen source is routed to the monitor output for rate counting. A monitor reset returns the node to the disarmed state at channel 0. All chain strobes are single-cycle pulses that are synchronous to the node clock.

Top module: `evmon_node`

## Requirements
- R1: After reset the scan-out is 0 and the monitor output is 0 whatever the source inputs carry. The stored record is all zeros, the channel is 0 and the node is disarmed.
- R2: A cycle with `trig` high loads the record. Bits 47:42 take `board_id`, bits 41:38 take `grp_sig`, bits 37:32 take the current monitor channel and bits 31:0 take `hits`.
- R3: In event mode (`ev_mode`=1) each `ev_shift` pulse moves the record one place towards the MSB, and `ev_si` enters bit 0. `ev_so` always shows bit 47, so the board-ID MSB leaves first. The node shifts whatever the address bus carries.
- R4: After 48 shift pulses the node holds exactly the 48 scan-in bits, in arrival order with the first at bit 47. A chain therefore flushes record after record through one output.
- R5: `ev_shift` pulses have no effect while `ev_mode`=0. When `trig` and a shift pulse fall in the same cycle, the load wins.
- R6: In monitor mode (`ev_mode`=0), the first `mon_step` pulse with `sel_addr` equal to `node_addr` arms the node at its current channel. While armed, `mon_out` is source[channel], where sources 0–31 are `hits[0..31]`, 32–35 are `cal_freq[0..3]` and 36–39 are `grp_sig[0..3]`. While disarmed, `mon_out` is 0.
- R7: Each further matching `mon_step` pulse on an armed node advances the channel by one.
- R8: The channel wraps from 39 back to 0.
- R9: `mon_step` pulses with a non-matching address, or with `ev_mode`=1, leave both the channel and the armed state unchanged.
- R10: `mon_clr` disarms the node and sets the channel to 0. It takes priority over a `mon_step` pulse in the same cycle.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_addr | input | 4 | Strapped position of this node on its chain |
| board_id | input | 6 | Strapped board identity placed in the record |
| hits | input | 32 | Strip-hit states |
| cal_freq | input | 4 | Calibration frequency sources for monitoring |
| grp_sig | input | 4 | Group (fold) signals, recorded and monitorable |
| trig | input | 1 | Final-trigger pulse, loads the record |
| ev_mode | input | 1 | 1 = event readout, 0 = monitor operation |
| sel_addr | input | 4 | Node select address from the controller |
| ev_shift | input | 1 | Event-clock strobe, one bit per pulse |
| ev_si | input | 1 | Scan-in from the upstream node |
| ev_so | output | 1 | Scan-out towards the controller |
| mon_step | input | 1 | Monitor-clock strobe |
| mon_clr | input | 1 | Monitor reset |
| mon_out | output | 1 | Selected monitor source, 0 when disarmed |

## Verification
The assertions assume that the strobes `trig`, `ev_shift`, `mon_step` and `mon_clr` are already synchronous to `clk`, each high for one cycle, and that the mode and address lines only change while no strobe is active. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It settles the mode and address before it issues a pulse. The only collisions it creates are the two the requirements define: a load against a shift, and a clear against a step.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

   // Default geometry of one plane node
   localparam int unsigned DEF_HIT_W  = 32;
   localparam int unsigned DEF_CAL_W  = 4;
   localparam int unsigned DEF_GRP_W  = 4;
   localparam int unsigned DEF_ID_W   = 6;
   localparam int unsigned DEF_CH_W   = 6;
   localparam int unsigned DEF_ADDR_W = 4;

   // Width of a record for a given geometry
   function automatic int unsigned rec_width(input int unsigned id_w, grp_w, ch_w, hit_w);
      return id_w + grp_w + ch_w + hit_w;
   endfunction

endpackage

// File: rtl/evmon_shreg.sv
module evmon_shreg #(
   parameter int unsigned W         = 48,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] load_val,
   input  logic         si,
   output logic         so
);

   logic [W-1:0] rec_q;

   generate
      if (W < 2) begin : g_bad_w
         $error("evmon_shreg: W must be at least 2");
      end
   endgenerate

   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rec_q <= '0;
            else if (load)   rec_q <= load_val;
            else if (shift)  rec_q <= {rec_q[W-2:0], si};
         end
         assign so = rec_q[W-1];

         AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
            (shift && !load) |=> (so == $past(rec_q[W-2]))) else $error("shift order"); // R3
      end else begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rec_q <= '0;
            else if (load)   rec_q <= load_val;
            else if (shift)  rec_q <= {si, rec_q[W-1:1]};
         end
         assign so = rec_q[0];

         AST_SHIFT_DN: assert property (@(posedge clk) disable iff (!rst_n)
            (shift && !load) |=> (so == $past(rec_q[1]))) else $error("shift order"); // R3
      end
   endgenerate

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (rec_q == $past(load_val))) else $error("load lost"); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !shift) |=> $stable(rec_q)) else $error("record moved"); // R5

endmodule

// File: rtl/evmon_monsel.sv
module evmon_monsel #(
   parameter int unsigned CH_W    = 6,
   parameter int unsigned NUM_SRC = 40
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mon_mode,
   input  logic            addr_hit,
   input  logic            step,
   input  logic            clr,
   output logic [CH_W-1:0] ch,
   output logic            armed
);

   localparam logic [CH_W-1:0] LAST = CH_W'(NUM_SRC - 1);

   generate
      if (NUM_SRC > (1 << CH_W)) begin : g_bad_src
         $error("evmon_monsel: NUM_SRC exceeds channel counter range");
      end
   endgenerate

   logic take;
   assign take = mon_mode & addr_hit & step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch    <= '0;
         armed <= 1'b0;
      end else if (clr) begin
         ch    <= '0;
         armed <= 1'b0;
      end else if (take) begin
         if (!armed)          armed <= 1'b1;
         else if (ch == LAST) ch    <= '0;
         else                 ch    <= ch + 1'b1;
      end
   end

   AST_CH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ch <= LAST) else $error("channel out of range"); // R8
   AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !clr && armed && ch == LAST) |=> (ch == '0)) else $error("no wrap"); // R8
   AST_ARM_KEEPS_CH: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !clr && !armed) |=> (armed && $stable(ch))) else $error("arm moved channel"); // R6
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!armed && ch == '0)) else $error("clear failed"); // R10
   AST_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !take) |=> ($stable(ch) && $stable(armed))) else $error("stray step"); // R9

endmodule

// File: rtl/evmon_mux.sv
module evmon_mux #(
   parameter int unsigned N     = 40,
   parameter int unsigned SEL_W = 6
) (
   input  logic [N-1:0]     src,
   input  logic [SEL_W-1:0] sel,
   input  logic             en,
   output logic             out
);

   generate
      if (N == (1 << SEL_W)) begin : g_full
         assign out = en & src[sel];
      end else begin : g_partial
         logic pick;
         always_comb begin
            pick = 1'b0;
            for (int i = 0; i < N; i++) begin
               if (sel == SEL_W'(i)) pick = src[i];
            end
         end
         assign out = en & pick;
      end
   endgenerate

   always_comb begin
      if (!en) AST_QUIET_OFF: assert (out == 1'b0) else $error("output while disarmed"); // R6
   end

endmodule

// File: rtl/evmon_node.sv
module evmon_node
   import evmon_pkg::*;
#(
   parameter int unsigned HIT_W     = DEF_HIT_W,
   parameter int unsigned CAL_W     = DEF_CAL_W,
   parameter int unsigned GRP_W     = DEF_GRP_W,
   parameter int unsigned ID_W      = DEF_ID_W,
   parameter int unsigned CH_W      = DEF_CH_W,
   parameter int unsigned ADDR_W    = DEF_ADDR_W,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] node_addr,
   input  logic [ID_W-1:0]   board_id,
   input  logic [HIT_W-1:0]  hits,
   input  logic [CAL_W-1:0]  cal_freq,
   input  logic [GRP_W-1:0]  grp_sig,
   input  logic              trig,
   input  logic              ev_mode,
   input  logic [ADDR_W-1:0] sel_addr,
   input  logic              ev_shift,
   input  logic              ev_si,
   output logic              ev_so,
   input  logic              mon_step,
   input  logic              mon_clr,
   output logic              mon_out
);

   localparam int unsigned NUM_SRC = HIT_W + CAL_W + GRP_W;
   localparam int unsigned REC_W   = rec_width(ID_W, GRP_W, CH_W, HIT_W);

   generate
      if (NUM_SRC > (1 << CH_W)) begin : g_bad_ch
         $error("evmon_node: channel field too narrow for source count");
      end
      if (ADDR_W == 0) begin : g_bad_addr
         $error("evmon_node: address width must be nonzero");
      end
   endgenerate

   logic [CH_W-1:0]    mon_ch;
   logic               mon_armed;
   logic [REC_W-1:0]   rec_in;
   logic [NUM_SRC-1:0] mon_src;

   assign rec_in  = {board_id, grp_sig, mon_ch, hits};
   assign mon_src = {grp_sig, cal_freq, hits};

   evmon_shreg #(
      .W         (REC_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_shreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (trig),
      .shift    (ev_mode & ev_shift),
      .load_val (rec_in),
      .si       (ev_si),
      .so       (ev_so)
   );

   evmon_monsel #(
      .CH_W    (CH_W),
      .NUM_SRC (NUM_SRC)
   ) u_monsel (
      .clk      (clk),
      .rst_n    (rst_n),
      .mon_mode (~ev_mode),
      .addr_hit (sel_addr == node_addr),
      .step     (mon_step),
      .clr      (mon_clr),
      .ch       (mon_ch),
      .armed    (mon_armed)
   );

   evmon_mux #(
      .N     (NUM_SRC),
      .SEL_W (CH_W)
   ) u_mux (
      .src (mon_src),
      .sel (mon_ch),
      .en  (mon_armed),
      .out (mon_out)
   );

   AST_EVMODE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_mode && !mon_clr) |=> ($stable(mon_ch) && $stable(mon_armed))) else $error("step in event mode"); // R9
   AST_MONMODE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_mode && !trig) |=> $stable(ev_so)) else $error("shift in monitor mode"); // R5

endmodule

// File: tb/evmon_node_tb.sv
module evmon_node_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] MY_ADDR = 4'd9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  board_id = 6'h2D;
   logic [31:0] hits = '0;
   logic [3:0]  cal_freq = '0;
   logic [3:0]  grp_sig = '0;
   logic        trig = 0, ev_mode = 1, ev_shift = 0, ev_si = 0;
   logic [3:0]  sel_addr = '0;
   logic        mon_step = 0, mon_clr = 0;
   logic        ev_so, mon_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evmon_node u_dut (
      .clk(clk), .rst_n(rst_n), .node_addr(MY_ADDR), .board_id(board_id),
      .hits(hits), .cal_freq(cal_freq), .grp_sig(grp_sig), .trig(trig),
      .ev_mode(ev_mode), .sel_addr(sel_addr), .ev_shift(ev_shift), .ev_si(ev_si),
      .ev_so(ev_so), .mon_step(mon_step), .mon_clr(mon_clr), .mon_out(mon_out)
   );

   // {board_id, grp_sig, hits}
   localparam logic [41:0] VEC [4] = '{
      {6'h3F, 4'hA, 32'h8000_0001},
      {6'h15, 4'h3, 32'hDEAD_BEEF},
      {6'h00, 4'h0, 32'h0000_0000},
      {6'h2A, 4'hF, 32'h5A5A_F00F}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_rec();
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
   endtask

   // Check every bit of exp on ev_so while feeding si in (first bit fed = si[47])
   task automatic drain(input logic [47:0] exp, input logic [47:0] si, input string req);
      for (int i = 0; i < 48; i++) begin
         chk(req, {63'd0, ev_so}, {63'd0, exp[47-i]});
         ev_shift = 1'b1;
         ev_si    = si[47-i];
         @(negedge clk);
         ev_shift = 1'b0;
      end
   endtask

   task automatic step(input logic [3:0] a);
      sel_addr = a;
      mon_step = 1'b1;
      @(negedge clk);
      mon_step = 1'b0;
   endtask

   function automatic logic src_bit(input int c);
      logic [39:0] s;
      s = {grp_sig, cal_freq, hits};
      return s[c];
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [47:0] exp, si;
      hits = '1; cal_freq = '1; grp_sig = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 scan-out", {63'd0, ev_so}, 64'd0);
      chk("R1 monitor off", {63'd0, mon_out}, 64'd0);
      ev_mode = 1'b1;
      hits = '0; cal_freq = '0; grp_sig = '0;
      drain(48'd0, 48'd0, "R1 record zero");

      // R2 R3 R4: table of records, shifted out and refilled
      foreach (VEC[k]) begin
         board_id = VEC[k][41:36];
         grp_sig  = VEC[k][35:32];
         hits     = VEC[k][31:0];
         sel_addr = 4'(k);                 // shifting ignores address
         load_rec();
         exp = {VEC[k][41:32], 6'd0, VEC[k][31:0]};
         si  = {exp[23:0], ~exp[47:24]};
         drain(exp, si, "R2 R3 record shift");
         drain(si, 48'd0, "R4 chain flush");
      end

      // R5: shifts ignored in monitor mode
      hits = 32'h1234_5678; grp_sig = 4'h6; board_id = 6'h11;
      load_rec();
      exp = {6'h11, 4'h6, 6'd0, 32'h1234_5678};
      ev_mode = 1'b0;
      for (int i = 0; i < 5; i++) begin
         ev_shift = 1'b1; ev_si = 1'b0;
         @(negedge clk);
         ev_shift = 1'b0;
      end
      ev_mode = 1'b1;
      drain(exp, 48'd0, "R5 no shift in monitor mode");
      // R5: load wins over a same-cycle shift
      hits = 32'hCAFE_0001;
      trig = 1'b1; ev_shift = 1'b1; ev_si = 1'b1;
      @(negedge clk);
      trig = 1'b0; ev_shift = 1'b0;
      drain({6'h11, 4'h6, 6'd0, 32'hCAFE_0001}, 48'd0, "R5 load priority");

      // Monitor operation
      hits = 32'hA5C3_0F96; cal_freq = 4'b1010; grp_sig = 4'b0110;
      ev_mode = 1'b0;
      // R9: non-matching address ignored
      step(4'd3);
      step(4'd3);
      chk("R9 foreign address", {63'd0, mon_out}, 64'd0);
      // R6: first matching pulse arms at channel 0
      step(MY_ADDR);
      chk("R6 armed ch0", {63'd0, mon_out}, {63'd0, src_bit(0)});
      hits[0] = 1'b1;
      #1 chk("R6 live source", {63'd0, mon_out}, 64'd1);
      hits[0] = 1'b0;
      #1 chk("R6 live source", {63'd0, mon_out}, 64'd0);
      // R7: walk all channels
      for (int c = 1; c < 40; c++) begin
         step(MY_ADDR);
         chk($sformatf("R7 channel %0d", c), {63'd0, mon_out}, {63'd0, src_bit(c)});
      end
      // R8: wrap
      step(MY_ADDR);
      chk("R8 wrap to 0", {63'd0, mon_out}, {63'd0, src_bit(0)});
      // advance to channel 5, then record captures channel
      for (int c = 1; c <= 5; c++) step(MY_ADDR);
      chk("R7 channel 5", {63'd0, mon_out}, {63'd0, src_bit(5)});
      // R9: pulse in event mode ignored
      ev_mode = 1'b1;
      step(MY_ADDR);
      ev_mode = 1'b0;
      step(4'd2);
      chk("R9 event-mode pulse", {63'd0, mon_out}, {63'd0, src_bit(5)});
      // R2: record carries current channel
      board_id = 6'h07;
      load_rec();
      ev_mode = 1'b1;
      drain({6'h07, 4'b0110, 6'd5, 32'hA5C3_0F96}, 48'd0, "R2 channel field");
      ev_mode = 1'b0;
      // R10: clear beats step
      sel_addr = MY_ADDR;
      mon_clr = 1'b1; mon_step = 1'b1;
      @(negedge clk);
      mon_clr = 1'b0; mon_step = 1'b0;
      hits = '1;
      #1 chk("R10 disarmed", {63'd0, mon_out}, 64'd0);
      hits = 32'hA5C3_0F96;
      step(MY_ADDR);
      chk("R10 rearm at 0", {63'd0, mon_out}, {63'd0, src_bit(0)});
      step(MY_ADDR);
      chk("R10 next is 1", {63'd0, mon_out}, {63'd0, src_bit(1)});

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule